// File: doc/BRIEF.md
# Sequence-Triggered Logic Capture Core

This block is a small on-chip capture engine for debugging a digital design from inside the chip. On every enabled sample tick it takes a snapshot of a 17-channel probe bus. One slice of that bus, sixteen channels wide by default, forms a compare group. The remaining channel usually carries a slow clock or strobe. It is stored with every sample but never takes part in triggering.

Software or a test sequencer first loads a trigger mode, two masked patterns and a capture length, then pulses `arm`. The trigger can be a single masked value. It can also be a two-step sequence: pattern A, then pattern B on the very next enabled sample. The sample that completes the trigger goes into buffer address 0. The following enabled samples fill the addresses after it until the programmed count is reached, and then `done` rises. The buffer can be read back through a synchronous read port.

A sample-enable input, normally driven by an external divider, lets the core record at a fraction of its clock rate without any change to the capture logic.

Top module: `la_capture_core`

## Requirements
- R1: After reset `done` is 0 and the core is idle. Without an `arm` pulse no sample is ever captured and `done` stays 0, whatever the probe shows.
- R2: An `arm` pulse in the idle or done state clears `done` and starts waiting for a trigger on the next cycle. An `arm` pulse while waiting or capturing has no effect on the capture under way.
- R3: A pattern compares only the group bits whose mask bit is 1. A mask bit of 0 makes that group bit a don't-care, and an all-zero mask matches every sample.
- R4: In single mode (`seq_mode`=0) the first enabled sample whose group matches pattern A is the trigger sample, and it is stored at buffer address 0.
- R5: In sequence mode (`seq_mode`=1) the trigger sample is the first enabled sample that matches pattern B and directly follows an enabled sample that matched pattern A. That sample is stored at address 0.
- R6: In sequence mode, after an A match, an enabled sample that matches neither pattern drops the core back to waiting for A. A sample that matches A again (and not B) keeps the core waiting for B.
- R7: After the trigger, each following enabled sample is written at the next address. Exactly `cap_last`+1 samples are stored in total, from address 0 to `cap_last`, and `done` goes to 1 on the clock edge that writes the last one. A `cap_last` of 0 gives a one-sample capture.
- R8: While `smp_en` is 0 the probe is not sampled. Trigger progress and the write position hold still.
- R9: `rd_data` shows the full 17-bit buffer word at `rd_addr` one clock after the address is applied. After `done`, further probe activity leaves the buffer unchanged.
- R10: Only group channels 15..0 are compared. Channel 16 is stored in every sample but never affects a match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_en | input | 1 | Sample tick; the probe is sampled only when it is high |
| probe | input | 17 | Probe channels; bits 15..0 form the compare group |
| seq_mode | input | 1 | 0 = single-pattern trigger, 1 = A-then-B sequence |
| pat_a | input | 16 | Pattern A value |
| mask_a | input | 16 | Pattern A compare mask, 1 = compare |
| pat_b | input | 16 | Pattern B value |
| mask_b | input | 16 | Pattern B compare mask, 1 = compare |
| arm | input | 1 | Start strobe, taken in idle or done |
| cap_last | input | 6 | Last buffer address to fill (samples stored = value + 1) |
| done | output | 1 | Capture complete |
| rd_addr | input | 6 | Buffer read address |
| rd_data | output | 17 | Buffer word, one clock after `rd_addr` |

## Verification
A wrong trigger state shows up as `done` rising on the wrong edge, or as the read-back buffer holding a shifted window. For example, if the matcher skipped a dropped A, address 0 would hold a B sample that did not directly follow an A. A broken write counter shows in the buffer as gaps, repeated words or a word count that does not match `cap_last`. A broken sample-enable gate would record samples that were never offered on an enabled tick. `done` is compared on every cycle against a reference model, so a wrong state transition is caught on the edge it happens. Buffer contents are compared word by word after every capture.

// File: rtl/la_pkg.sv
package la_pkg;
   typedef enum logic [2:0] {
      LA_IDLE    = 3'd0,
      LA_ARMED   = 3'd1,
      LA_SEEN    = 3'd2,
      LA_CAPTURE = 3'd3,
      LA_DONE    = 3'd4
   } la_state_e;
endpackage

// File: rtl/la_match.sv
module la_match #(
   parameter int GRP_W = 16
) (
   input  logic [GRP_W-1:0] grp,
   input  logic [GRP_W-1:0] pat,
   input  logic [GRP_W-1:0] mask,
   output logic             hit
);
   logic [GRP_W-1:0] miss;

   if (GRP_W < 1) begin : g_bad_width
      $error("la_match: GRP_W must be positive");
   end

   for (genvar b = 0; b < GRP_W; b++) begin : g_bit
      assign miss[b] = mask[b] & (grp[b] ^ pat[b]);
   end

   assign hit = ~|miss;
endmodule

// File: rtl/la_capture_ram.sv
module la_capture_ram #(
   parameter int DEPTH  = 64,
   parameter int DATA_W = 17,
   parameter bit RD_REG = 1'b1,
   localparam int ADDR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] mem [DEPTH];

   if (DEPTH < 2) begin : g_bad_depth
      $error("la_capture_ram: DEPTH must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   if (RD_REG) begin : g_rd_reg
      always_ff @(posedge clk) rdata <= mem[raddr];
   end else begin : g_rd_comb
      assign rdata = mem[raddr];
   end
endmodule

// File: rtl/la_trig_fsm.sv
module la_trig_fsm
   import la_pkg::*;
#(
   parameter int ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              smp_en,
   input  logic              arm,
   input  logic              seq_mode,
   input  logic              hit_a,
   input  logic              hit_b,
   input  logic [ADDR_W-1:0] cap_last,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic              done
);
   la_state_e         state_q, state_d;
   logic [ADDR_W-1:0] cnt_q, cnt_d;
   logic              fire;

   always_comb begin
      state_d = state_q;
      cnt_d   = cnt_q;
      fire    = 1'b0;
      wr_en   = 1'b0;
      unique case (state_q)
         LA_IDLE, LA_DONE: begin
            if (arm) state_d = LA_ARMED;
         end
         LA_ARMED: begin
            if (smp_en && hit_a) begin
               if (seq_mode) state_d = LA_SEEN;
               else          fire    = 1'b1;
            end
         end
         LA_SEEN: begin
            if (smp_en) begin
               if (hit_b)       fire    = 1'b1;
               else if (!hit_a) state_d = LA_ARMED;
            end
         end
         LA_CAPTURE: begin
            if (smp_en) begin
               wr_en = 1'b1;
               if (cnt_q == cap_last) state_d = LA_DONE;
               else                   cnt_d   = cnt_q + ADDR_W'(1);
            end
         end
         default: state_d = LA_IDLE;
      endcase
      if (fire) begin
         wr_en   = 1'b1;
         cnt_d   = ADDR_W'(1);
         state_d = (cap_last == '0) ? LA_DONE : LA_CAPTURE;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= LA_IDLE;
         cnt_q   <= '0;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
      end
   end

   assign wr_addr = (state_q == LA_CAPTURE) ? cnt_q : '0;
   assign done    = (state_q == LA_DONE);

   p_wr_in_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (wr_addr <= cap_last));
   p_done_after_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(wr_en));
   p_arm_takes_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (arm && (state_q == LA_IDLE || state_q == LA_DONE)) |=> (state_q == LA_ARMED));
   p_arm_no_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (arm && !smp_en && state_q == LA_CAPTURE) |=> (state_q == LA_CAPTURE && $stable(cnt_q)));
   p_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!smp_en && !arm) |=> ($stable(state_q) && $stable(cnt_q)));
   p_no_write_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !wr_en);
   p_first_at_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == '0) |-> (state_q == LA_ARMED || state_q == LA_SEEN));
   p_idle_no_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == LA_IDLE) |-> !wr_en);
endmodule

// File: rtl/la_capture_core.sv
module la_capture_core #(
   parameter int CHAN_W  = 17,
   parameter int GRP_LSB = 0,
   parameter int GRP_W   = 16,
   parameter int DEPTH   = 64,
   parameter bit RD_REG  = 1'b1,
   localparam int ADDR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              smp_en,
   input  logic [CHAN_W-1:0] probe,
   input  logic              seq_mode,
   input  logic [GRP_W-1:0]  pat_a,
   input  logic [GRP_W-1:0]  mask_a,
   input  logic [GRP_W-1:0]  pat_b,
   input  logic [GRP_W-1:0]  mask_b,
   input  logic              arm,
   input  logic [ADDR_W-1:0] cap_last,
   output logic              done,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [CHAN_W-1:0] rd_data
);
   if (GRP_LSB + GRP_W > CHAN_W) begin : g_bad_group
      $error("la_capture_core: compare group exceeds probe width");
   end
   if ((1 << ADDR_W) != DEPTH) begin : g_bad_pow2
      $error("la_capture_core: DEPTH must be a power of two");
   end

   logic [GRP_W-1:0]  grp;
   logic              hit_a, hit_b, wr_en;
   logic [ADDR_W-1:0] wr_addr;

   assign grp = probe[GRP_LSB +: GRP_W];

   la_match #(.GRP_W(GRP_W)) i_match_a (
      .grp(grp), .pat(pat_a), .mask(mask_a), .hit(hit_a));
   la_match #(.GRP_W(GRP_W)) i_match_b (
      .grp(grp), .pat(pat_b), .mask(mask_b), .hit(hit_b));

   la_trig_fsm #(.ADDR_W(ADDR_W)) i_fsm (
      .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .arm(arm),
      .seq_mode(seq_mode), .hit_a(hit_a), .hit_b(hit_b),
      .cap_last(cap_last), .wr_en(wr_en), .wr_addr(wr_addr), .done(done));

   la_capture_ram #(.DEPTH(DEPTH), .DATA_W(CHAN_W), .RD_REG(RD_REG)) i_ram (
      .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(probe),
      .raddr(rd_addr), .rdata(rd_data));
endmodule

// File: tb/test_la_capture_core.sv
module test_la_capture_core;
   localparam int CW = 17, GW = 16, DEPTH = 64, AW = 6;
   localparam int S_IDLE = 0, S_ARMED = 1, S_SEEN = 2, S_CAP = 3, S_DONE = 4;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic          rst_n, smp_en, seq_mode, arm, done;
   logic [CW-1:0] probe, rd_data;
   logic [GW-1:0] pat_a, mask_a, pat_b, mask_b;
   logic [AW-1:0] cap_last, rd_addr;

   la_capture_core i_la_capture_core (
      .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .probe(probe),
      .seq_mode(seq_mode), .pat_a(pat_a), .mask_a(mask_a), .pat_b(pat_b),
      .mask_b(mask_b), .arm(arm), .cap_last(cap_last), .done(done),
      .rd_addr(rd_addr), .rd_data(rd_data));

   int errors = 0, checks = 0;
   string req = "R1";
   int m_state, m_cnt;
   logic [CW-1:0] m_mem [DEPTH];
   bit finished = 0;

   task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp, input string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", r, what, act, exp);
      end
   endtask

   function automatic bit hits(input logic [CW-1:0] p, input logic [GW-1:0] pt, input logic [GW-1:0] mk);
      return ((p[GW-1:0] ^ pt) & mk) == '0;
   endfunction

   task automatic model_trig(input logic [CW-1:0] p);
      m_mem[0] = p;
      if (cap_last == 0) m_state = S_DONE;
      else begin m_state = S_CAP; m_cnt = 1; end
   endtask

   task automatic model(input bit a, input bit en, input logic [CW-1:0] p);
      bit ha = hits(p, pat_a, mask_a);
      bit hb = hits(p, pat_b, mask_b);
      if (a && (m_state == S_IDLE || m_state == S_DONE)) m_state = S_ARMED;
      else if (en) begin
         case (m_state)
            S_ARMED: if (ha) begin
               if (seq_mode) m_state = S_SEEN; else model_trig(p);
            end
            S_SEEN: if (hb) model_trig(p); else if (!ha) m_state = S_ARMED;
            S_CAP: begin
               m_mem[m_cnt] = p;
               if (m_cnt == int'(cap_last)) m_state = S_DONE; else m_cnt++;
            end
            default: ;
         endcase
      end
   endtask

   task automatic step(input bit a, input bit en, input logic [CW-1:0] p);
      @(negedge clk);
      arm = a; smp_en = en; probe = p;
      @(posedge clk);
      model(a, en, p);
      #1;
      chk(req, {31'd0, done}, {31'd0, m_state == S_DONE}, "done");
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; arm = 1'b0; smp_en = 1'b0;
      @(posedge clk); @(negedge clk);
      rst_n = 1'b1;
      m_state = S_IDLE; m_cnt = 0;
      #1;
      chk("R1", {31'd0, done}, 32'd0, "done after reset");
   endtask

   task automatic read_buf(input string r);
      for (int i = 0; i <= int'(cap_last); i++) begin
         @(negedge clk);
         arm = 1'b0; smp_en = 1'b0; rd_addr = AW'(i);
         @(posedge clk); #1;
         chk(r, {15'd0, rd_data}, {15'd0, m_mem[i]}, $sformatf("buffer[%0d]", i));
      end
   endtask

   task automatic setup(input bit sq, input logic [GW-1:0] pa, input logic [GW-1:0] ma,
                        input logic [GW-1:0] pb, input logic [GW-1:0] mb, input int cl);
      @(negedge clk);
      seq_mode = sq; pat_a = pa; mask_a = ma; pat_b = pb; mask_b = mb; cap_last = AW'(cl);
   endtask

   initial begin
      #(4 * 150000);
      if (!finished) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [GW-1:0] ctr;
      logic [CW-1:0] seq6 [10];
      void'($urandom(32'd7391));
      rst_n = 1'b0; arm = 1'b0; smp_en = 1'b0; probe = '0; rd_addr = '0;
      seq_mode = 1'b0; pat_a = '0; mask_a = '1; pat_b = '0; mask_b = '1; cap_last = '0;
      repeat (3) @(posedge clk);
      do_reset();

      // R1: matching samples without arm never capture
      req = "R1";
      setup(0, 16'h0000, 16'hFFFF, 16'h0, 16'hFFFF, 3);
      for (int i = 0; i < 8; i++) step(0, 1, '0);

      // R4 R8 R10: single trigger on 0000, random enable gaps, ch16 toggling
      req = "R4";
      setup(0, 16'h0000, 16'hFFFF, 16'h0, 16'hFFFF, 9);
      step(1, 0, '0);
      ctr = 16'hFFF9;
      for (int i = 0; i < 60; i++) begin
         bit en = ($urandom % 3) != 0;
         step(0, en, {i[0], ctr});
         if (en) ctr++;
      end
      req = "R9";
      for (int i = 0; i < 10; i++) step(0, 1, CW'($urandom));
      read_buf("R4 R7 R8 R10");

      // R2: arm during capture ignored
      req = "R2";
      setup(0, 16'h0005, 16'hFFFF, 16'h0, 16'hFFFF, 15);
      step(1, 1, '0);
      for (int i = 0; i < 30; i++) step(i == 10 || i == 12, (i % 5) != 3, CW'(i));
      read_buf("R2");

      // R5: down counter, 222 then 221
      req = "R5";
      setup(1, 16'd222, 16'hFFFF, 16'd221, 16'hFFFF, 7);
      step(1, 1, '0);
      for (int v = 235; v > 190; v--) step(0, 1, {1'b1, 16'(v)});
      read_buf("R5");

      // R6: broken and repeated A before B
      req = "R6";
      seq6 = '{17'd222, 17'd100, 17'd221, 17'd222, 17'd222, 17'd5, 17'd222, 17'd221, 17'd40, 17'd41};
      setup(1, 16'd222, 16'hFFFF, 16'd221, 16'hFFFF, 1);
      step(1, 1, '0);
      for (int i = 0; i < 10; i++) step(0, 1, seq6[i]);
      chk("R6", {15'd0, m_mem[0]}, 32'd221, "model trigger word");
      read_buf("R6");

      // R3 and one-sample capture boundary
      req = "R3";
      setup(0, 16'h12AB, 16'hFF00, 16'h0, 16'hFFFF, 0);
      step(1, 1, '0);
      step(0, 1, 17'h01300); step(0, 1, 17'h002FF); step(0, 1, 17'h01255); step(0, 1, 17'h01256);
      read_buf("R3 R7");

      // R7: full-depth capture, all-don't-care mask
      req = "R7";
      setup(0, 16'h0, 16'h0000, 16'h0, 16'hFFFF, DEPTH - 1);
      step(1, 1, '0);
      for (int i = 0; i < 70; i++) step(0, 1, CW'($urandom));
      read_buf("R7");

      // random rounds with narrow masks (R3 R5 R6)
      for (int r = 0; r < 12; r++) begin
         do_reset();
         req = "R6";
         setup(r[0], 16'($urandom % 8), 16'h0007, 16'($urandom % 8), 16'($urandom % 8), int'($urandom % DEPTH));
         step(1, 1, '0);
         for (int i = 0; i < 180; i++) step(0, ($urandom % 4) != 0, CW'($urandom));
         if (m_state == S_DONE) read_buf("R5 R6 random");
      end

      finished = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule